// File: doc/BRIEF.md
# PTP Event Frame Timestamp Detector for an MII Channel

This block sits beside one Ethernet channel and listens to both nibble streams of its MII, transmit and receive, at the same time. Each direction has its own detector. A detector looks for the preamble-to-SFD transition. At that point it samples the free-running system time. It then counts nibbles through the frame and reads a message-type byte at a fixed offset. When the final CRC nibble of a fixed-length PTP event frame goes by and the type matched, the detector commits the sampled time into that direction's snapshot register.

The channel role decides which message each direction stamps. A master stamps Sync frames it sends and Delay_Req frames it receives. A slave does the reverse. A committed snapshot raises a per-direction event bit, and software polls that bit because no interrupt is produced. While the bit is set, later matches are locked out until software clears it. The exception is when the lock-inhibit input is high: then every match overwrites the snapshot, which suits traffic analysis.

Top module: `ptp_mii_stamper`

## Requirements
- R1: The transmit and receive detectors work independently, so frames overlapping in time on both directions are each stamped.
- R2: With `master_mode` high, only transmitted Sync frames (type byte 0x00) and received Delay_Req frames (type byte 0x01) are stamped.
- R3: With `master_mode` low, only transmitted Delay_Req frames (0x01) and received Sync frames (0x00) are stamped.
- R4: The stamp equals the `sys_time` value present in the cycle where the SFD nibble 0xD is sampled.
- R5: Counting from the first nibble after the SFD as nibble 0, the commit happens on the clock edge that samples nibble 339, which is the high nibble of byte 169. The snapshot and event bit show the new values right after that edge.
- R6: While an event bit is set and `lock_inhibit` is low, further matches in that direction leave the snapshot unchanged.
- R7: A high `*_evt_clr` in a cycle clears the event bit at that edge. If a commit falls on the same edge, the commit is accepted and the bit stays set with the new stamp.
- R8: A frame whose data-valid drops before nibble 339 changes neither the snapshot nor the event bit.
- R9: The type is byte 74 after the SFD, assembled low nibble first (nibble 148 is bits 3:0, nibble 149 is bits 7:4). Any value other than the one wanted for that direction aborts the capture.
- R10: With `lock_inhibit` high, each match overwrites the snapshot even when the event bit is already set.
- R11: After reset both snapshots and both event bits are zero.
- R12: A frame starts only when 0xD directly follows a 0x5 nibble with data-valid high throughout. Any other nibble in the preamble discards the frame until data-valid goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MII-synchronous clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_nib | input | 4 | Transmit nibble |
| tx_dv | input | 1 | Transmit nibble valid |
| rx_nib | input | 4 | Receive nibble |
| rx_dv | input | 1 | Receive nibble valid |
| sys_time | input | TIME_W | Current system time |
| master_mode | input | 1 | 1 = channel is master, 0 = slave |
| lock_inhibit | input | 1 | 1 = matches overwrite a held snapshot |
| tx_evt_clr | input | 1 | Clears the transmit event bit |
| rx_evt_clr | input | 1 | Clears the receive event bit |
| tx_snap | output | TIME_W | Transmit-direction snapshot |
| tx_evt | output | 1 | Transmit snapshot held |
| rx_snap | output | TIME_W | Receive-direction snapshot |
| rx_evt | output | 1 | Receive snapshot held |

## Verification
The stamp is the `sys_time` value held while the SFD nibble is driven, so the bench records that value one nanosecond after driving the nibble. The snapshot and event bit change on the edge that samples nibble 339, with no further delay, and an event clear takes effect on the edge that samples it. A behavioural reference model updates at each rising edge from the same inputs. The outputs are compared with it one nanosecond later, so every result is checked in the cycle it is due. Directed checks after each frame, taken while data-valid is low, confirm the settled snapshots against the recorded SFD times.

// File: rtl/ptp_stamp_pkg.sv
package ptp_stamp_pkg;

    typedef enum logic [1:0] {
        DS_IDLE,
        DS_PREAMBLE,
        DS_BODY,
        DS_SKIP
    } det_state_e;

    localparam logic [3:0] NIB_PRE = 4'h5;
    localparam logic [3:0] NIB_SFD = 4'hD;

    localparam logic [7:0] MSG_SYNC = 8'h00;
    localparam logic [7:0] MSG_DREQ = 8'h01;

endpackage

// File: rtl/ptp_frame_detect.sv
module ptp_frame_detect
    import ptp_stamp_pkg::*;
#(
    parameter int TIME_W    = 64,
    parameter int LAST_BYTE = 169,
    parameter int TYPE_BYTE = 74
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        nib,
    input  logic              dv,
    input  logic [TIME_W-1:0] sys_time,
    input  logic [7:0]        want_type,
    output logic              commit,
    output logic [TIME_W-1:0] stamp
);

    localparam int CNT_W = $clog2(2 * (LAST_BYTE + 1) + 1);
    localparam logic [CNT_W-1:0] LAST_NIB = CNT_W'(2 * LAST_BYTE + 1);
    localparam logic [CNT_W-1:0] TYPE_LO  = CNT_W'(2 * TYPE_BYTE);
    localparam logic [CNT_W-1:0] TYPE_HI  = CNT_W'(2 * TYPE_BYTE + 1);

    typedef struct packed {
        det_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [3:0]        lo_nib;
        logic [TIME_W-1:0] stamp;
    } det_reg_t;

    det_reg_t r_q, r_d;
    logic     commit_d;

    always_comb begin
        r_d      = r_q;
        commit_d = 1'b0;
        unique case (r_q.state)
            DS_IDLE: begin
                if (dv) begin
                    r_d.state = (nib == NIB_PRE) ? DS_PREAMBLE : DS_SKIP;
                end
            end
            DS_PREAMBLE: begin
                if (!dv) begin
                    r_d.state = DS_IDLE;
                end else if (nib == NIB_SFD) begin
                    r_d.state  = DS_BODY;
                    r_d.cnt    = '0;
                    r_d.stamp  = sys_time;
                    r_d.lo_nib = '0;
                end else if (nib != NIB_PRE) begin
                    r_d.state = DS_SKIP;
                end
            end
            DS_BODY: begin
                if (!dv) begin
                    r_d.state = DS_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == TYPE_LO) begin
                        r_d.lo_nib = nib;
                    end
                    if (r_q.cnt == TYPE_HI && {nib, r_q.lo_nib} != want_type) begin
                        r_d.state = DS_SKIP;
                    end
                    if (r_q.cnt == LAST_NIB) begin
                        commit_d  = 1'b1;
                        r_d.state = DS_SKIP;
                    end
                end
            end
            DS_SKIP: begin
                if (!dv) begin
                    r_d.state = DS_IDLE;
                end
            end
            default: r_d.state = DS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state  <= DS_IDLE;
            r_q.cnt    <= '0;
            r_q.lo_nib <= '0;
            r_q.stamp  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign commit = commit_d;
    assign stamp  = r_q.stamp;

endmodule

// File: rtl/ptp_snap_latch.sv
module ptp_snap_latch #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [TIME_W-1:0] stamp,
    input  logic              clr,
    input  logic              inhibit,
    output logic [TIME_W-1:0] snap,
    output logic              evt
);

    typedef struct packed {
        logic [TIME_W-1:0] snap;
        logic              evt;
    } snap_reg_t;

    snap_reg_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.evt = 1'b0;
        end
        if (commit && (!s_d.evt || inhibit)) begin
            s_d.snap = stamp;
            s_d.evt  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign snap = s_q.snap;
    assign evt  = s_q.evt;

endmodule

// File: rtl/ptp_mii_stamper.sv
module ptp_mii_stamper
    import ptp_stamp_pkg::*;
#(
    parameter int TIME_W    = 64,
    parameter int LAST_BYTE = 169,
    parameter int TYPE_BYTE = 74
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        tx_nib,
    input  logic              tx_dv,
    input  logic [3:0]        rx_nib,
    input  logic              rx_dv,
    input  logic [TIME_W-1:0] sys_time,
    input  logic              master_mode,
    input  logic              lock_inhibit,
    input  logic              tx_evt_clr,
    input  logic              rx_evt_clr,
    output logic [TIME_W-1:0] tx_snap,
    output logic              tx_evt,
    output logic [TIME_W-1:0] rx_snap,
    output logic              rx_evt
);

    localparam int NDIR = 2;

    logic [3:0]        nib_a   [NDIR];
    logic              dv_a    [NDIR];
    logic              clr_a   [NDIR];
    logic [7:0]        want_a  [NDIR];
    logic [TIME_W-1:0] stamp_a [NDIR];
    logic [TIME_W-1:0] snap_a  [NDIR];
    logic              evt_a   [NDIR];
    logic [NDIR-1:0]   det_commit;

    always_comb begin
        nib_a[0]  = tx_nib;
        dv_a[0]   = tx_dv;
        clr_a[0]  = tx_evt_clr;
        want_a[0] = master_mode ? MSG_SYNC : MSG_DREQ;
        nib_a[1]  = rx_nib;
        dv_a[1]   = rx_dv;
        clr_a[1]  = rx_evt_clr;
        want_a[1] = master_mode ? MSG_DREQ : MSG_SYNC;
    end

    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        ptp_frame_detect #(
            .TIME_W    (TIME_W),
            .LAST_BYTE (LAST_BYTE),
            .TYPE_BYTE (TYPE_BYTE)
        ) u_det (
            .clk       (clk),
            .rst_n     (rst_n),
            .nib       (nib_a[g]),
            .dv        (dv_a[g]),
            .sys_time  (sys_time),
            .want_type (want_a[g]),
            .commit    (det_commit[g]),
            .stamp     (stamp_a[g])
        );

        ptp_snap_latch #(
            .TIME_W (TIME_W)
        ) u_snap (
            .clk     (clk),
            .rst_n   (rst_n),
            .commit  (det_commit[g]),
            .stamp   (stamp_a[g]),
            .clr     (clr_a[g]),
            .inhibit (lock_inhibit),
            .snap    (snap_a[g]),
            .evt     (evt_a[g])
        );
    end

    assign tx_snap = snap_a[0];
    assign tx_evt  = evt_a[0];
    assign rx_snap = snap_a[1];
    assign rx_evt  = evt_a[1];

endmodule

// File: rtl/ptp_mii_stamper_chk.sv
module ptp_mii_stamper_chk #(
    parameter int TIME_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_dv,
    input logic              rx_dv,
    input logic              lock_inhibit,
    input logic              tx_evt_clr,
    input logic              rx_evt_clr,
    input logic [1:0]        commit,
    input logic [TIME_W-1:0] tx_snap,
    input logic              tx_evt,
    input logic [TIME_W-1:0] rx_snap,
    input logic              rx_evt
);

    AST_TX_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_evt && !tx_evt_clr |=> tx_evt); // R6
    AST_RX_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt && !rx_evt_clr |=> rx_evt); // R6
    AST_TX_SNAP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_evt && !lock_inhibit && !tx_evt_clr |=> $stable(tx_snap)); // R6
    AST_RX_SNAP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt && !lock_inhibit && !rx_evt_clr |=> $stable(rx_snap)); // R6
    AST_TX_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_evt_clr && !commit[0] |=> !tx_evt); // R7
    AST_RX_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt_clr && !commit[1] |=> !rx_evt); // R7
    AST_TX_RISE_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_evt) |-> $past(commit[0]) && $past(tx_dv)); // R5
    AST_RX_RISE_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_evt) |-> $past(commit[1]) && $past(rx_dv)); // R5
    AST_TX_SNAP_NEEDS_DV: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_snap) |-> $past(tx_dv)); // R8
    AST_RX_SNAP_NEEDS_DV: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_snap) |-> $past(rx_dv)); // R8

endmodule

bind ptp_mii_stamper ptp_mii_stamper_chk #(.TIME_W(TIME_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_dv        (tx_dv),
    .rx_dv        (rx_dv),
    .lock_inhibit (lock_inhibit),
    .tx_evt_clr   (tx_evt_clr),
    .rx_evt_clr   (rx_evt_clr),
    .commit       (det_commit),
    .tx_snap      (tx_snap),
    .tx_evt       (tx_evt),
    .rx_snap      (rx_snap),
    .rx_evt       (rx_evt)
);

// File: tb/ptp_mii_stamper_test.sv
`timescale 1ns/1ps
module ptp_mii_stamper_test;

    localparam int TW    = 64;
    localparam int LB    = 169;
    localparam int TB    = 74;
    localparam int FULL  = LB + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    tx_nib = '0, rx_nib = '0;
    logic          tx_dv = 1'b0, rx_dv = 1'b0;
    logic [TW-1:0] sys_time = 64'h1000;
    logic          master_mode = 1'b1, lock_inhibit = 1'b0;
    logic          tx_evt_clr = 1'b0, rx_evt_clr = 1'b0;
    logic [TW-1:0] tx_snap, rx_snap;
    logic          tx_evt, rx_evt;

    int n_chk = 0;
    int n_fail = 0;
    logic [TW-1:0] t_tx, t_rx;

    always #2 clk = ~clk;
    always @(negedge clk) sys_time <= sys_time + 64'd7;

    ptp_mii_stamper #(.TIME_W(TW), .LAST_BYTE(LB), .TYPE_BYTE(TB)) uut (
        .clk(clk), .rst_n(rst_n),
        .tx_nib(tx_nib), .tx_dv(tx_dv), .rx_nib(rx_nib), .rx_dv(rx_dv),
        .sys_time(sys_time), .master_mode(master_mode), .lock_inhibit(lock_inhibit),
        .tx_evt_clr(tx_evt_clr), .rx_evt_clr(rx_evt_clr),
        .tx_snap(tx_snap), .tx_evt(tx_evt), .rx_snap(rx_snap), .rx_evt(rx_evt)
    );

    task automatic chk(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model: phase 0 idle, 1 preamble, 2 in frame, 3 discard.
    int            m_phase [2];
    int            m_seen  [2];
    int            m_type  [2];
    logic [TW-1:0] m_t     [2];
    logic [TW-1:0] m_snap  [2];
    bit            m_evt   [2];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < 2; d++) begin
                m_phase[d] = 0; m_seen[d] = 0; m_type[d] = 0;
                m_t[d] = '0; m_snap[d] = '0; m_evt[d] = 0;
            end
        end else begin
            for (int d = 0; d < 2; d++) begin
                bit v, c, hit;
                int n, want;
                v = (d == 0) ? tx_dv : rx_dv;
                n = (d == 0) ? int'(tx_nib) : int'(rx_nib);
                c = (d == 0) ? tx_evt_clr : rx_evt_clr;
                want = ((d == 0) == master_mode) ? 0 : 1;
                hit = 0;
                if (!v) m_phase[d] = 0;
                else if (m_phase[d] == 0) m_phase[d] = (n == 5) ? 1 : 3;
                else if (m_phase[d] == 1) begin
                    if (n == 13) begin m_phase[d] = 2; m_seen[d] = 0; m_t[d] = sys_time; m_type[d] = 0; end
                    else if (n != 5) m_phase[d] = 3;
                end else if (m_phase[d] == 2) begin
                    if (m_seen[d] / 2 == TB) m_type[d] += (m_seen[d] % 2 == 1) ? n * 16 : n;
                    if (m_seen[d] == 2 * TB + 1 && m_type[d] != want) m_phase[d] = 3;
                    else if (m_seen[d] == 2 * FULL - 1) begin hit = 1; m_phase[d] = 3; end
                    m_seen[d]++;
                end
                if (c) m_evt[d] = 0;
                if (hit && (!m_evt[d] || lock_inhibit)) begin m_evt[d] = 1; m_snap[d] = m_t[d]; end
            end
            #1;
            chk("R5 tx event per cycle", {63'd0, tx_evt}, {63'd0, m_evt[0]});
            chk("R5 tx snapshot per cycle", tx_snap, m_snap[0]);
            chk("R1 rx event per cycle", {63'd0, rx_evt}, {63'd0, m_evt[1]});
            chk("R1 rx snapshot per cycle", rx_snap, m_snap[1]);
        end
    end

    function automatic logic [3:0] nib_at(input int i, input logic [7:0] ty, input bit bad_pre);
        int k, b;
        logic [7:0] val;
        if (i < 15) return (bad_pre && i == 13) ? 4'h3 : 4'h5;
        if (i == 15) return 4'hD;
        k = i - 16;
        b = k / 2;
        val = (b == TB) ? ty : 8'((b * 37 + 11) & 255);
        return (k % 2 == 1) ? val[7:4] : val[3:0];
    endfunction

    task automatic send(input bit dt, input logic [7:0] tt, input int tl,
                        input bit dr, input logic [7:0] rt, input int rl,
                        input bit bad_pre, input bit clr_last);
        int ntx, nrx, nmax;
        ntx = dt ? 16 + 2 * tl : 0;
        nrx = dr ? 16 + 2 * rl : 0;
        nmax = (ntx > nrx) ? ntx : nrx;
        for (int i = 0; i < nmax; i++) begin
            @(negedge clk);
            tx_dv = (i < ntx); tx_nib = (i < ntx) ? nib_at(i, tt, bad_pre) : 4'h0;
            rx_dv = (i < nrx); rx_nib = (i < nrx) ? nib_at(i, rt, bad_pre) : 4'h0;
            tx_evt_clr = clr_last && (i == ntx - 1);
            #1;
            if (i == 15) begin t_tx = sys_time; t_rx = sys_time; end
        end
        @(negedge clk);
        tx_dv = 0; rx_dv = 0; tx_nib = 0; rx_nib = 0; tx_evt_clr = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_both();
        @(negedge clk); tx_evt_clr = 1; rx_evt_clr = 1;
        @(negedge clk); tx_evt_clr = 0; rx_evt_clr = 0;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [TW-1:0] keep;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R11 tx_evt after reset", {63'd0, tx_evt}, 0);
        chk("R11 rx_evt after reset", {63'd0, rx_evt}, 0);
        chk("R11 tx_snap after reset", tx_snap, 0);
        chk("R11 rx_snap after reset", rx_snap, 0);

        // R2 / R1: master, tx Sync and rx Delay_Req at once
        master_mode = 1;
        send(1, 8'h00, FULL, 1, 8'h01, FULL, 0, 0);
        chk("R2 master tx Sync event", {63'd0, tx_evt}, 1);
        chk("R4 tx stamp at SFD", tx_snap, t_tx);
        chk("R1 concurrent rx Delay_Req event", {63'd0, rx_evt}, 1);
        chk("R4 rx stamp at SFD", rx_snap, t_rx);
        keep = tx_snap;

        // R6: lockout
        send(1, 8'h00, FULL, 0, 8'h00, 0, 0, 0);
        chk("R6 locked tx snapshot", tx_snap, keep);

        clear_both();
        chk("R7 tx event cleared", {63'd0, tx_evt}, 0);
        chk("R7 rx event cleared", {63'd0, rx_evt}, 0);

        // R2: wrong directions in master mode
        send(1, 8'h01, FULL, 1, 8'h00, FULL, 0, 0);
        chk("R2 master tx Delay_Req ignored", {63'd0, tx_evt}, 0);
        chk("R2 master rx Sync ignored", {63'd0, rx_evt}, 0);

        // R3: slave mode
        master_mode = 0;
        send(1, 8'h01, FULL, 1, 8'h00, FULL, 0, 0);
        chk("R3 slave tx Delay_Req event", {63'd0, tx_evt}, 1);
        chk("R3 slave tx stamp", tx_snap, t_tx);
        chk("R3 slave rx Sync event", {63'd0, rx_evt}, 1);
        chk("R3 slave rx stamp", rx_snap, t_rx);
        clear_both();

        // R8: truncated frames
        send(1, 8'h01, FULL - 1, 1, 8'h00, 100, 0, 0);
        chk("R8 truncated tx no event", {63'd0, tx_evt}, 0);
        chk("R8 truncated rx no event", {63'd0, rx_evt}, 0);

        // R9: bad type values, nibble order
        send(1, 8'h10, FULL, 1, 8'h02, FULL, 0, 0);
        chk("R9 tx type 0x10 rejected", {63'd0, tx_evt}, 0);
        chk("R9 rx type 0x02 rejected", {63'd0, rx_evt}, 0);

        // R12: broken preamble
        send(1, 8'h01, FULL, 1, 8'h00, FULL, 1, 0);
        chk("R12 tx bad preamble ignored", {63'd0, tx_evt}, 0);
        chk("R12 rx bad preamble ignored", {63'd0, rx_evt}, 0);

        // R10: lock inhibit overwrites
        lock_inhibit = 1;
        send(1, 8'h01, FULL, 0, 8'h00, 0, 0, 0);
        keep = tx_snap;
        send(1, 8'h01, FULL, 0, 8'h00, 0, 0, 0);
        chk("R10 overwrite event stays", {63'd0, tx_evt}, 1);
        chk("R10 overwritten snapshot", tx_snap, t_tx);
        chk("R10 snapshot changed", {63'd0, tx_snap != keep}, 1);

        // R7: clear coincident with commit, lock active
        lock_inhibit = 0;
        send(1, 8'h01, FULL, 0, 8'h00, 0, 0, 1);
        chk("R7 commit wins over clear event", {63'd0, tx_evt}, 1);
        chk("R7 commit wins over clear snap", tx_snap, t_tx);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule